// File: doc/BRIEF.md
# Post-Scale Clock Divider Bank

Six independent output clock dividers share one high-rate source clock and turn it into six slower clocks. Each channel divides by its own ratio, so several output rates come from one common source rate. A channel runs in one of two duty modes. Balanced mode aims for 50% high time. Custom mode takes an explicit split between high cycles and low cycles.

Each channel also has a phase offset in two parts. The coarse part delays the first output edge by whole source cycles after a reload. The fine part selects one of eight phase taps, spaced one eighth of a source period apart. A ratio of 1 passes the selected tap straight through. In balanced mode with an odd ratio, the high phase is stretched by half a source period. That half comes from the tap on the opposite edge.

A single write port loads settings into a channel. Each write is validated first, and an invalid write is refused. A valid setting waits until the channel reaches the end of its current period, and only then takes effect.

Top module: `cdb_clk_div_bank`

## Requirements
- R1: Each of the six channels runs independently from the shared source clock. A channel with ratio R repeats its output pattern every R source cycles.
- R2: Balanced mode accepts ratios 1 through 512. With an even ratio R, the output is high for R/2 cycles and then low for R/2 cycles. A balanced write with a ratio above 512 is refused.
- R3: Custom mode (`wr_custom_i`=1) accepts ratios 1 through 256. A custom write with a ratio above 256 is refused.
- R4: In custom mode with R>1, the output is high for `wr_high_i` cycles and then low for `wr_low_i` cycles. A custom write with R>1 is refused when high+low differs from R, or when either field is zero.
- R5: Balanced mode with an odd R>1 gives this pattern in each period:
  - high for floor(R/2) cycles;
  - then one cycle in which the output equals `taps_i[(fine+4) mod 8]`;
  - then low for floor(R/2) cycles.
- R6: With R=1 the output equals `taps_i[fine]` in every cycle. The high and low fields and the duty mode are ignored.
- R7: After a reload the output stays low for `coarse` cycles, and then the period starts with its first high cycle.
- R8: A write is refused in the following cases:
  - the ratio is 0;
  - the channel index is 6 or more;
  - any of the cases in R2 to R4.
  A refused write raises `err_o` for exactly one cycle, right after the write edge, and every channel keeps its previous settings.
- R9: An accepted write takes effect only after the target channel finishes its current period with the old settings.
- R10: While `srst_i` is sampled high, all outputs are low. The first edge with `srst_i` low restarts every channel at period position 0. The coarse delay of R7 then follows.
- R11: `en_i[n]`=0 forces `clk_o[n]` low while counting continues. When the enable returns, the output resumes at the phase it would have had without the interruption.
- R12: While `rst_ni` is low, outputs and `err_o` are low. After reset every channel uses these settings: ratio 2, balanced mode, coarse 0, fine 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-rate source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous restart of all channels |
| en_i | input | 6 | Per-channel output enable |
| taps_i | input | 8 | Eight phase taps of the source clock |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_ch_i | input | 3 | Target channel index |
| wr_ratio_i | input | 10 | Division ratio |
| wr_high_i | input | 10 | High cycles (custom mode) |
| wr_low_i | input | 10 | Low cycles (custom mode) |
| wr_custom_i | input | 1 | 1 = custom duty split, 0 = balanced |
| wr_coarse_i | input | 4 | Coarse delay in source cycles |
| wr_fine_i | input | 3 | Phase tap select |
| err_o | output | 1 | One-cycle flag for a refused write |
| clk_o | output | 6 | Divided output clocks |

## Verification
Each result is due at a fixed cycle, and the checks wait for exactly that cycle:
- `err_o` is due in the cycle right after the write edge. The bench reads it at the next falling edge.
- After `srst_i` is released, one edge restarts the channels. Sample k after that edge then shows period position k−coarse. The bench predicts every sample from the stored settings.
- A write made in mid-period is checked by expecting the old pattern up to its terminal count, and the new pattern from the following sample onward.

Outputs are sampled on the falling edge, and inputs change only there.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int RATIO_W  = 10;
  localparam int COARSE_W = 4;
  localparam int N_TAPS   = 8;
  localparam int FINE_W   = $clog2(N_TAPS);

  typedef struct packed {
    logic [RATIO_W-1:0]  ratio;
    logic [RATIO_W-1:0]  high;
    logic                custom;
    logic                stretch;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } cfg_t;

  localparam cfg_t CFG_RST = '{
    ratio:   RATIO_W'(2),
    high:    RATIO_W'(1),
    custom:  1'b0,
    stretch: 1'b0,
    coarse:  '0,
    fine:    '0
  };
endpackage

// File: rtl/cdb_cfg_check.sv
module cdb_cfg_check
  import cdb_pkg::*;
#(
  parameter int MAX_BAL  = 512,
  parameter int MAX_CUST = 256
) (
  input  logic [RATIO_W-1:0]  ratio_i,
  input  logic [RATIO_W-1:0]  high_i,
  input  logic [RATIO_W-1:0]  low_i,
  input  logic                custom_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                ok_o,
  output cfg_t                cfg_o
);
  localparam logic [RATIO_W:0] LIM_BAL  = (RATIO_W+1)'(MAX_BAL);
  localparam logic [RATIO_W:0] LIM_CUST = (RATIO_W+1)'(MAX_CUST);

  logic [RATIO_W:0] sum;
  logic [RATIO_W:0] limit;
  logic             is_one;
  logic             duty_ok;

  assign sum     = {1'b0, high_i} + {1'b0, low_i};
  assign limit   = custom_i ? LIM_CUST : LIM_BAL;
  assign is_one  = ratio_i == RATIO_W'(1);
  assign duty_ok = !custom_i || is_one ||
                   (sum == {1'b0, ratio_i} && high_i != '0 && low_i != '0);
  assign ok_o    = ratio_i != '0 && {1'b0, ratio_i} <= limit && duty_ok;

  always_comb begin
    cfg_o.ratio   = ratio_i;
    cfg_o.high    = custom_i ? high_i : (ratio_i >> 1);
    cfg_o.custom  = custom_i;
    // odd balanced ratio: half-period stretch from opposite tap
    cfg_o.stretch = !custom_i && ratio_i[0] && !is_one;
    cfg_o.coarse  = coarse_i;
    cfg_o.fine    = fine_i;
  end
endmodule

// File: rtl/cdb_tap_sel.sv
module cdb_tap_sel
  import cdb_pkg::*;
(
  input  logic [N_TAPS-1:0] taps_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic              main_o,
  output logic              opp_o
);
  localparam logic [FINE_W-1:0] HALF = FINE_W'(N_TAPS / 2);

  logic [FINE_W-1:0] opp_idx;

  assign opp_idx = fine_i ^ HALF;
  assign main_o  = taps_i[fine_i];
  assign opp_o   = taps_i[opp_idx];
endmodule

// File: rtl/cdb_channel.sv
module cdb_channel
  import cdb_pkg::*;
#(
  parameter int MAX_BAL  = 512,
  parameter int MAX_CUST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              en_i,
  input  logic              load_i,
  input  cfg_t              cfg_i,
  input  logic [N_TAPS-1:0] taps_i,
  output logic              clk_o
);
  cfg_t                act_q, pend_q;
  logic                pend_v_q;
  logic [RATIO_W-1:0]  cnt_q;
  logic [COARSE_W-1:0] phase_q;
  logic                run_q;

  logic tc, bypass, active, lvl, ext, tap_main, tap_opp;

  assign tc     = cnt_q == act_q.ratio - RATIO_W'(1);
  assign bypass = act_q.ratio == RATIO_W'(1);
  assign active = run_q && phase_q == '0;
  assign lvl    = cnt_q < act_q.high;
  assign ext    = act_q.stretch && cnt_q == act_q.high;

  cdb_tap_sel u_tap (
    .taps_i (taps_i),
    .fine_i (act_q.fine),
    .main_o (tap_main),
    .opp_o  (tap_opp)
  );

  assign clk_o = en_i && active && (bypass ? tap_main : (lvl || (ext && tap_opp)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= CFG_RST;
      pend_q   <= CFG_RST;
      pend_v_q <= 1'b0;
      cnt_q    <= '0;
      phase_q  <= '0;
      run_q    <= 1'b0;
    end else begin
      if (srst_i) begin
        cnt_q   <= '0;
        phase_q <= act_q.coarse;
        run_q   <= 1'b0;
      end else if (!run_q) begin
        run_q <= 1'b1;
      end else if (phase_q != '0) begin
        phase_q <= phase_q - COARSE_W'(1);
      end else if (tc) begin
        cnt_q <= '0;
        if (pend_v_q) begin
          act_q    <= pend_q;
          pend_v_q <= 1'b0;
          phase_q  <= pend_q.coarse;
        end
      end else begin
        cnt_q <= cnt_q + RATIO_W'(1);
      end
      // a write in the same cycle wins over the consume above
      if (load_i) begin
        pend_q   <= cfg_i;
        pend_v_q <= 1'b1;
      end
    end
  end

  p_cnt_in_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q.ratio);

  p_ratio_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.ratio != '0 &&
    (act_q.custom ? int'(act_q.ratio) <= MAX_CUST : int'(act_q.ratio) <= MAX_BAL));

  p_coarse_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != '0 |-> cnt_q == '0 && !clk_o);

  p_reload_at_tc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(act_q) |-> $past(tc) && $past(active) && !$past(srst_i));

  p_srst_align_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_i) |-> cnt_q == '0 && !clk_o);
endmodule

// File: rtl/cdb_clk_div_bank.sv
module cdb_clk_div_bank
  import cdb_pkg::*;
#(
  parameter  int N_CH     = 6,
  parameter  int MAX_BAL  = 512,
  parameter  int MAX_CUST = 256,
  localparam int CH_W     = $clog2(N_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                srst_i,
  input  logic [N_CH-1:0]     en_i,
  input  logic [N_TAPS-1:0]   taps_i,
  input  logic                wr_en_i,
  input  logic [CH_W-1:0]     wr_ch_i,
  input  logic [RATIO_W-1:0]  wr_ratio_i,
  input  logic [RATIO_W-1:0]  wr_high_i,
  input  logic [RATIO_W-1:0]  wr_low_i,
  input  logic                wr_custom_i,
  input  logic [COARSE_W-1:0] wr_coarse_i,
  input  logic [FINE_W-1:0]   wr_fine_i,
  output logic                err_o,
  output logic [N_CH-1:0]     clk_o
);
  logic            cfg_ok, ch_ok, wr_ok;
  cfg_t            wr_cfg;
  logic [N_CH-1:0] load;
  logic            err_q;

  cdb_cfg_check #(.MAX_BAL(MAX_BAL), .MAX_CUST(MAX_CUST)) u_check (
    .ratio_i  (wr_ratio_i),
    .high_i   (wr_high_i),
    .low_i    (wr_low_i),
    .custom_i (wr_custom_i),
    .coarse_i (wr_coarse_i),
    .fine_i   (wr_fine_i),
    .ok_o     (cfg_ok),
    .cfg_o    (wr_cfg)
  );

  assign ch_ok = int'(wr_ch_i) < N_CH;
  assign wr_ok = cfg_ok && ch_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= wr_en_i && !wr_ok;
  end
  assign err_o = err_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign load[g] = wr_en_i && wr_ok && int'(wr_ch_i) == g;

    cdb_channel #(.MAX_BAL(MAX_BAL), .MAX_CUST(MAX_CUST)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .srst_i (srst_i),
      .en_i   (en_i[g]),
      .load_i (load[g]),
      .cfg_i  (wr_cfg),
      .taps_i (taps_i),
      .clk_o  (clk_o[g])
    );
  end

  p_err_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i));

  p_one_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load));

  p_srst_outputs_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_i) |-> clk_o == '0);
endmodule

// File: tb/cdb_clk_div_bank_tb_top.sv
module cdb_clk_div_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srst = 1'b0;
  logic [5:0] en = 6'h3f;
  logic [7:0] taps = 8'b1010_0110;
  logic       wr_en = 1'b0;
  logic [2:0] wr_ch = '0;
  logic [9:0] wr_ratio = '0, wr_high = '0, wr_low = '0;
  logic       wr_custom = 1'b0;
  logic [3:0] wr_coarse = '0;
  logic [2:0] wr_fine = '0;
  logic       err;
  logic [5:0] clk_out;

  int n_chk = 0, n_fail = 0;
  int m_ratio[6], m_high[6], m_custom[6], m_coarse[6], m_fine[6];

  cdb_clk_div_bank dut_i (
    .clk_i (clk), .rst_ni (rst_n), .srst_i (srst), .en_i (en), .taps_i (taps),
    .wr_en_i (wr_en), .wr_ch_i (wr_ch), .wr_ratio_i (wr_ratio), .wr_high_i (wr_high),
    .wr_low_i (wr_low), .wr_custom_i (wr_custom), .wr_coarse_i (wr_coarse),
    .wr_fine_i (wr_fine), .err_o (err), .clk_o (clk_out)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_out(int ch, int k, logic [7:0] tp);
    int p, h;
    if (k < m_coarse[ch]) return 1'b0;
    p = (k - m_coarse[ch]) % m_ratio[ch];
    if (m_ratio[ch] == 1) return tp[m_fine[ch]];
    if (m_custom[ch] != 0) return p < m_high[ch];
    h = m_ratio[ch] / 2;
    if (p < h) return 1'b1;
    if ((m_ratio[ch] % 2) == 1 && p == h) return tp[(m_fine[ch] + 4) % 8];
    return 1'b0;
  endfunction

  task automatic wr(int ch, int ratio, int high, int low, int custom, int coarse,
                    int fine, bit exp_err, string req);
    @(negedge clk);
    wr_ch = 3'(ch); wr_ratio = 10'(ratio); wr_high = 10'(high); wr_low = 10'(low);
    wr_custom = custom[0]; wr_coarse = 4'(coarse); wr_fine = 3'(fine); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(err == exp_err, {req, " err after write"}, int'(err), int'(exp_err));
    if (exp_err) begin
      @(negedge clk);
      check(err == 1'b0, {req, " err lasts one cycle"}, int'(err), 0);
    end else begin
      m_ratio[ch] = ratio; m_custom[ch] = custom; m_coarse[ch] = coarse; m_fine[ch] = fine;
      m_high[ch] = custom != 0 ? high : ratio / 2;
    end
  endtask

  task automatic settle();
    repeat (1100) @(negedge clk);
  endtask

  // R10: restart all channels; outputs low while restart is sampled
  task automatic align();
    @(negedge clk);
    srst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(clk_out == '0, "R10 outputs low in restart", int'(clk_out), 0);
    srst = 1'b0;
  endtask

  task automatic compare_all(int n, string req);
    int bad[6], a[6], e[6];
    foreach (bad[c]) bad[c] = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int c = 0; c < 6; c++) begin
        logic x;
        x = exp_out(c, k, taps);
        if (clk_out[c] !== x && bad[c] == 0) begin
          bad[c] = 1; a[c] = int'(clk_out[c]); e[c] = int'(x);
          $display("  ch%0d mismatch at sample %0d", c, k);
        end
      end
    end
    for (int c = 0; c < 6; c++) check(bad[c] == 0, req, a[c], e[c]);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(clk_out == '0, "R12 outputs low in reset", int'(clk_out), 0);
    check(err == 1'b0, "R12 err low in reset", int'(err), 0);
    for (int c = 0; c < 6; c++) begin
      m_ratio[c] = 2; m_high[c] = 1; m_custom[c] = 0; m_coarse[c] = 0; m_fine[c] = 0;
    end
    rst_n = 1'b1;
    align();
    compare_all(12, "R12 default ratio 2");
  endtask

  task automatic t_channels();
    wr(0, 4, 0, 0, 0, 0, 0, 1'b0, "R1");
    wr(1, 6, 9, 9, 0, 0, 0, 1'b0, "R2");
    wr(2, 5, 2, 3, 1, 0, 0, 1'b0, "R4");
    wr(3, 5, 0, 0, 0, 0, 1, 1'b0, "R5");
    wr(4, 1, 7, 9, 1, 0, 6, 1'b0, "R6");
    wr(5, 2, 0, 0, 0, 3, 0, 1'b0, "R7");
    settle();
    taps = 8'b1010_0110;
    align();
    compare_all(40, "R1/R4/R5/R6/R7 pattern A");
    taps = 8'b0101_1001;
    align();
    compare_all(40, "R1/R5/R6/R7 pattern B");
  endtask

  task automatic t_limits();
    wr(0, 512, 0, 0, 0, 0, 0, 1'b0, "R2 accept 512");
    settle();
    align();
    compare_all(520, "R2 ratio 512");
    wr(0, 513, 0, 0, 0, 0, 0, 1'b1, "R2 reject 513");
    wr(0, 257, 128, 129, 1, 0, 0, 1'b1, "R3 reject custom 257");
    wr(0, 6, 2, 3, 1, 0, 0, 1'b1, "R4 reject sum");
    wr(0, 4, 0, 4, 1, 0, 0, 1'b1, "R4 reject zero high");
    wr(0, 0, 0, 0, 0, 0, 0, 1'b1, "R8 reject ratio 0");
    wr(6, 4, 0, 0, 0, 0, 0, 1'b1, "R8 reject channel 6");
    settle();
    align();
    compare_all(520, "R8 settings kept");
    wr(0, 256, 100, 156, 1, 0, 0, 1'b0, "R3 accept custom 256");
    settle();
    align();
    compare_all(260, "R3/R4 custom 256");
  endtask

  task automatic t_reload();
    int bad = 0, a = 0, e = 0;
    wr(1, 8, 0, 0, 0, 0, 0, 1'b0, "R9");
    settle();
    align();
    for (int k = 0; k < 24; k++) begin
      logic x;
      @(negedge clk);
      x = (k < 8) ? ((k % 8) < 4) : (((k - 8) % 4) < 2);
      if (clk_out[1] !== x && bad == 0) begin
        bad = 1; a = int'(clk_out[1]); e = int'(x);
        $display("  reload mismatch at sample %0d", k);
      end
      if (k == 2) begin
        wr_ch = 3'd1; wr_ratio = 10'd4; wr_high = '0; wr_low = '0;
        wr_custom = 1'b0; wr_coarse = '0; wr_fine = '0; wr_en = 1'b1;
      end
      if (k == 3) begin
        wr_en = 1'b0;
        check(err == 1'b0, "R9 write accepted", int'(err), 0);
      end
    end
    check(bad == 0, "R9 old period completes before reload", a, e);
    m_ratio[1] = 4; m_high[1] = 2; m_custom[1] = 0; m_coarse[1] = 0; m_fine[1] = 0;
  endtask

  task automatic t_enable();
    int bad = 0, a = 0, e = 0;
    align();
    for (int k = 0; k < 16; k++) begin
      logic x;
      @(negedge clk);
      x = (k >= 3 && k <= 6) ? 1'b0 : exp_out(2, k, taps);
      if (clk_out[2] !== x && bad == 0) begin
        bad = 1; a = int'(clk_out[2]); e = int'(x);
        $display("  enable mismatch at sample %0d", k);
      end
      if (k == 2) en[2] = 1'b0;
      if (k == 6) en[2] = 1'b1;
    end
    check(bad == 0, "R11 enable gates and phase kept", a, e);
  endtask

  initial begin
    t_reset();
    t_channels();
    t_limits();
    t_reload();
    t_enable();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule